// File: doc/BRIEF.md
# Dual-Clock FIFO with Heading-Flag Full/Empty Detection

This block carries fixed-width data words from a write clock domain to an unrelated read clock domain. Storage holds a power-of-two number of words. Each side owns a binary pointer and a Gray-coded copy of it. Only the Gray copy crosses to the other side, through two flip-flops clocked in the receiving domain.

The pointers have exactly as many bits as the storage address. No extra wrap bit is kept. Equal pointers can mean either "all slots used" or "no slots used", so each domain keeps a one-bit heading register to tell the two apart. The register turns toward full when the write pointer's top two bits sit one quadrant behind the read pointer's. It turns toward empty when they sit one quadrant ahead. In all other cases it holds its value. Full is produced in the write domain and empty in the read domain, each registered there.

Both flags are pessimistic, because the pointer seen from the other side is late. They may hold on after the opposite side has freed a slot or supplied a word, but they never let an overflow or an underflow through. A request made while the matching flag is high is dropped. The heading registers are only updated at the moments they sample the other pointer, so the two clocks must not differ by a factor of a quarter of the depth or more.

Top module: `adir_fifo`

## Requirements
- R1: After both resets, full is 0, empty is 1 and rdata is 0.
- R2: Words are read out in the order they were accepted. Each accepted read (ren high while empty is low at a rising rclk) places its word on rdata at that same edge, so the word is valid during the following rclk cycle.
- R3: With no reads, exactly DEPTH writes are accepted, and full is high from the edge that accepts the last one. Writes attempted while full is high change nothing: the words read out later are exactly the DEPTH words accepted earlier.
- R4: A read attempted while empty is high leaves rdata unchanged and consumes no word.
- R5: Accepted writes minus accepted reads always stays between 0 and DEPTH.
- R6: After a read frees a slot of a full FIFO, full falls within 6 wclk cycles, given the stated clock ratio.
- R7: After one write into an empty FIFO, empty falls within 6 rclk cycles.
- R8: Operation stays correct across many wraps of both pointers. Each Gray pointer that crosses domains changes at most one bit per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| wrst | input | 1 | Write-side synchronous reset, active high |
| wen | input | 1 | Write request |
| wdata | input | DATA_W | Word to store |
| full | output | 1 | No free slot; write requests are dropped |
| rclk | input | 1 | Read-side clock |
| rrst | input | 1 | Read-side synchronous reset, active high |
| ren | input | 1 | Read request |
| rdata | output | DATA_W | Registered output word |
| empty | output | 1 | No stored word; read requests are dropped |

## Verification
The case that matters is a write and a read landing close together while the pointers are about to meet. The read side then retires a word the write side has not yet seen leave, and the write side adds a word the read side has not yet seen arrive. Two concurrent phases provoke this. In one, a fast writer keeps the FIFO pinned at full while a slower reader drains it. In the other, a sparse writer lets the reader keep hitting empty. Every returned word is compared with a reference queue, every dropped request is checked for lack of effect, and the occupancy counted from accepted requests must never leave 0..DEPTH.

// File: rtl/adf_pkg.sv
package adf_pkg;

    // Heading of the write pointer relative to the read pointer.
    typedef enum logic {
        TOWARD_EMPTY = 1'b0,
        TOWARD_FULL  = 1'b1
    } heading_e;

    // Quadrant test on the top two pointer bits.
    function automatic heading_e next_heading(input logic [1:0] wq,
                                              input logic [1:0] rq,
                                              input heading_e   cur);
        logic [1:0] behind;
        logic [1:0] ahead;
        behind = rq - 2'd1;
        ahead  = rq + 2'd1;
        if (wq == behind)     return TOWARD_FULL;
        else if (wq == ahead) return TOWARD_EMPTY;
        else                  return cur;
    endfunction

endpackage

// File: rtl/adf_sync.sv
module adf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/adf_ram.sv
module adf_ram #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              re,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] store [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    always_ff @(posedge rclk) begin
        if (rrst)    rdata <= '0;
        else if (re) rdata <= store[raddr];
    end

    // R4: output word holds when no read is accepted
    p_rdata_hold_r4: assert property (@(posedge rclk) disable iff (rrst)
        !re |=> $stable(rdata));
endmodule

// File: rtl/adf_wside.sv
module adf_wside
    import adf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              wclk,
    input  logic              wrst,
    input  logic              wen,
    input  logic [ADDR_W-1:0] rgray_s,
    output logic [ADDR_W-1:0] wbin,
    output logic [ADDR_W-1:0] wgray,
    output logic              full,
    output logic              fire
);
    logic [ADDR_W-1:0] bin_nx, gray_nx, rbin_s;
    heading_e          head_q, head_nx;
    logic              full_nx;

    always_comb begin
        rbin_s[ADDR_W-1] = rgray_s[ADDR_W-1];
        for (int i = ADDR_W - 2; i >= 0; i--)
            rbin_s[i] = rbin_s[i+1] ^ rgray_s[i];
    end

    assign fire    = wen & ~full;
    assign bin_nx  = wbin + ADDR_W'(fire);
    assign gray_nx = bin_nx ^ (bin_nx >> 1);
    assign head_nx = next_heading(bin_nx[ADDR_W-1 -: 2], rbin_s[ADDR_W-1 -: 2], head_q);
    assign full_nx = (bin_nx == rbin_s) && (head_nx == TOWARD_FULL);

    always_ff @(posedge wclk) begin
        if (wrst) begin
            wbin   <= '0;
            wgray  <= '0;
            head_q <= TOWARD_EMPTY;
            full   <= 1'b0;
        end else begin
            wbin   <= bin_nx;
            wgray  <= gray_nx;
            head_q <= head_nx;
            full   <= full_nx;
        end
    end

    // R3: a request while full moves nothing
    p_no_overflow_r3: assert property (@(posedge wclk) disable iff (wrst)
        (full && wen) |=> $stable(wbin));
    // R8: crossing pointer changes at most one bit per clock
    p_wgray_step_r8: assert property (@(posedge wclk) disable iff (wrst)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/adf_rside.sv
module adf_rside
    import adf_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              rclk,
    input  logic              rrst,
    input  logic              ren,
    input  logic [ADDR_W-1:0] wgray_s,
    output logic [ADDR_W-1:0] rbin,
    output logic [ADDR_W-1:0] rgray,
    output logic              empty,
    output logic              fire
);
    logic [ADDR_W-1:0] bin_nx, gray_nx, wbin_s;
    heading_e          head_q, head_nx;
    logic              empty_nx;

    always_comb begin
        wbin_s[ADDR_W-1] = wgray_s[ADDR_W-1];
        for (int i = ADDR_W - 2; i >= 0; i--)
            wbin_s[i] = wbin_s[i+1] ^ wgray_s[i];
    end

    assign fire     = ren & ~empty;
    assign bin_nx   = rbin + ADDR_W'(fire);
    assign gray_nx  = bin_nx ^ (bin_nx >> 1);
    assign head_nx  = next_heading(wbin_s[ADDR_W-1 -: 2], bin_nx[ADDR_W-1 -: 2], head_q);
    assign empty_nx = (bin_nx == wbin_s) && (head_nx == TOWARD_EMPTY);

    always_ff @(posedge rclk) begin
        if (rrst) begin
            rbin   <= '0;
            rgray  <= '0;
            head_q <= TOWARD_EMPTY;
            empty  <= 1'b1;
        end else begin
            rbin   <= bin_nx;
            rgray  <= gray_nx;
            head_q <= head_nx;
            empty  <= empty_nx;
        end
    end

    // R4: a request while empty moves nothing
    p_no_underflow_r4: assert property (@(posedge rclk) disable iff (rrst)
        (empty && ren) |=> $stable(rbin));
    // R8: crossing pointer changes at most one bit per clock
    p_rgray_step_r8: assert property (@(posedge rclk) disable iff (rrst)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/adir_fifo.sv
module adir_fifo #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 4   // at least 2: the quadrant test uses two bits
) (
    input  logic              wclk,
    input  logic              wrst,
    input  logic              wen,
    input  logic [DATA_W-1:0] wdata,
    output logic              full,
    input  logic              rclk,
    input  logic              rrst,
    input  logic              ren,
    output logic [DATA_W-1:0] rdata,
    output logic              empty
);
    logic [ADDR_W-1:0] wbin, wgray, rbin, rgray;
    logic [ADDR_W-1:0] wgray_s, rgray_s;
    logic              wfire, rfire;

    adf_wside #(.ADDR_W(ADDR_W)) u_wside (
        .wclk(wclk), .wrst(wrst), .wen(wen), .rgray_s(rgray_s),
        .wbin(wbin), .wgray(wgray), .full(full), .fire(wfire)
    );

    adf_rside #(.ADDR_W(ADDR_W)) u_rside (
        .rclk(rclk), .rrst(rrst), .ren(ren), .wgray_s(wgray_s),
        .rbin(rbin), .rgray(rgray), .empty(empty), .fire(rfire)
    );

    adf_sync #(.W(ADDR_W)) u_w2r (
        .clk(rclk), .rst(rrst), .d(wgray), .q(wgray_s)
    );

    adf_sync #(.W(ADDR_W)) u_r2w (
        .clk(wclk), .rst(wrst), .d(rgray), .q(rgray_s)
    );

    adf_ram #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ram (
        .wclk(wclk), .we(wfire), .waddr(wbin), .wdata(wdata),
        .rclk(rclk), .rrst(rrst), .re(rfire), .raddr(rbin), .rdata(rdata)
    );

    // R2: output word changes only after an accepted read
    p_rdata_source_r2: assert property (@(posedge rclk) disable iff (rrst)
        !$stable(rdata) |-> $past(ren && !empty));
endmodule

// File: tb/adir_fifo_test.sv
`timescale 1ns/1ps
module adir_fifo_test;
    localparam int DW    = 8;
    localparam int AW    = 4;
    localparam int DEPTH = 1 << AW;

    logic wclk = 0, rclk = 0;
    logic wrst = 1, rrst = 1;
    logic wen = 0, ren = 0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic full, empty;

    int nchk = 0, nfail = 0;
    int wr_cnt = 0, rd_cnt = 0;
    bit finished = 0;
    logic [DW-1:0] ref_q[$];
    logic [DW-1:0] last_rd = '0;

    always #4   wclk = ~wclk;   // 125 MHz
    always #6.5 rclk = ~rclk;

    adir_fifo #(.DATA_W(DW), .ADDR_W(AW)) uut (
        .wclk(wclk), .wrst(wrst), .wen(wen), .wdata(wdata), .full(full),
        .rclk(rclk), .rrst(rrst), .ren(ren), .rdata(rdata), .empty(empty)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one write attempt; held request, released by caller when idle
    task automatic wr(input logic [DW-1:0] d, output bit acc);
        @(negedge wclk);
        wen = 1; wdata = d;
        acc = !full;
        if (acc) begin
            ref_q.push_back(d);
            wr_cnt++;
            if (wr_cnt - rd_cnt > DEPTH) chk(0, "R5 overflow", wr_cnt - rd_cnt, DEPTH);
        end
    endtask

    task automatic wr_idle();
        @(negedge wclk); wen = 0;
    endtask

    // one read attempt, result judged one rclk later
    task automatic rd(output bit acc);
        logic [DW-1:0] exp;
        @(negedge rclk);
        ren = 1;
        acc = !empty;
        if (acc) rd_cnt++;
        @(negedge rclk);
        ren = 0;
        if (acc) begin
            if (ref_q.size() == 0) begin
                chk(0, "R5 underflow", rd_cnt, wr_cnt);
            end else begin
                exp = ref_q.pop_front();
                chk(rdata == exp, "R2 order", rdata, exp);
            end
            last_rd = rdata;
        end else begin
            chk(rdata == last_rd, "R4 ignored read", rdata, last_rd);
        end
    endtask

    task automatic run_mixed(input int total, input int wgap, input int rgap);
        int target;
        target = rd_cnt + total;
        fork
            begin : writer
                int sent;
                bit acc;
                logic [15:0] lcg;
                sent = 0; lcg = 16'h1234;
                while (sent < total) begin
                    lcg = lcg * 16'd25173 + 16'd13849;
                    if (lcg[15:12] < 4'(wgap)) begin
                        wr_idle();
                    end else begin
                        wr(DW'(sent * 13 + 5), acc);
                        if (acc) sent++;
                    end
                end
                wr_idle();
            end
            begin : reader
                bit acc;
                logic [15:0] lcg;
                lcg = 16'h9e37;
                while (rd_cnt < target) begin
                    lcg = lcg * 16'd25173 + 16'd13849;
                    if (lcg[15:12] < 4'(rgap)) @(negedge rclk);
                    else rd(acc);
                end
            end
        join
    endtask

    initial begin : main
        bit acc;
        int n;
        int k;
        repeat (4) @(negedge wclk);
        wrst = 0;
        @(negedge rclk); rrst = 0;
        repeat (2) @(negedge rclk);
        // R1 reset state
        chk(full == 0, "R1 full", full, 0);
        chk(empty == 1, "R1 empty", empty, 1);
        chk(rdata == 0, "R1 rdata", rdata, 0);

        // R3 fill with no reads; extra attempts must be dropped
        n = 0;
        for (int i = 0; i < DEPTH + 3; i++) begin
            wr(DW'(i + 1), acc);
            if (acc) n++;
        end
        wr_idle();
        chk(n == DEPTH, "R3 accepted writes", n, DEPTH);
        chk(full == 1, "R3 full", full, 1);

        // R7 data visible on read side, then R6 full released after one read
        repeat (8) @(negedge rclk);
        chk(empty == 0, "R7 empty low", empty, 0);
        rd(acc);
        chk(acc == 1, "R2 first read", acc, 1);
        k = 0;
        while (full && k < 8) begin @(negedge wclk); k++; end
        chk(k <= 6, "R6 full release cycles", k, 6);

        // drain: exactly DEPTH-1 more words, marker writes never appear
        n = 0;
        for (int i = 0; i < DEPTH + 2; i++) begin
            rd(acc);
            if (acc) n++;
        end
        chk(n == DEPTH - 1, "R3 drained words", n, DEPTH - 1);
        chk(empty == 1, "R4 empty after drain", empty, 1);
        chk(ref_q.size() == 0, "R5 queue drained", ref_q.size(), 0);

        // R7 single write into empty FIFO
        wr(8'hA5, acc);
        wr_idle();
        k = 0;
        while (empty && k < 8) begin @(negedge rclk); k++; end
        chk(k <= 6, "R7 empty release cycles", k, 6);
        rd(acc);
        rd(acc);
        chk(acc == 0, "R4 read after last word", acc, 0);

        // R8 concurrent traffic across many wraps: near full, then near empty
        run_mixed(300, 2, 1);
        run_mixed(300, 11, 0);
        repeat (10) @(negedge rclk);
        chk(ref_q.size() == 0, "R8 all words returned", ref_q.size(), 0);
        chk(empty == 1, "R8 empty at end", empty, 1);
        chk(wr_cnt == rd_cnt, "R5 balance", rd_cnt, wr_cnt);

        finished = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin : watchdog
        #(8 * 150000);
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule